// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt event of a clock-calendar peripheral. It counts ticks of a 32.768 kHz time base, given as a one-cycle enable strobe in the system clock domain, in a single free-running counter. It raises an event whenever that count reaches a multiple of the period chosen by a 4-bit rate code. Each event is a one-cycle pulse. With it come a status mask that the neighbouring register block ORs into its status register and an interrupt request strobe.

The rate code and the periodic-enable bit come straight from the control registers held elsewhere. A change to either takes effect from the next tick. Because every rate code watches the same counter, the first event after a change falls on the next boundary of the new period, not one full period after the write. Register storage, calendar counting and bus decoding sit outside the block.

Top module: `periodic_irq_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `evt_o` and `irq_req_o` are 0 and `stat_set_o` is 0x00. The tick count restarts from zero.
- R2: A rate code of 0 produces no event, whatever the enable bit and the ticks.
- R3: With `pie_en` low, no event is produced for any rate code.
- R4: For rate codes 3 to 15 with `pie_en` high, consecutive events are exactly 2^(code-1) ticks apart.
- R5: Rate codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 ticks.
- R6: An event occurs only on the tick that brings the free-running 16-bit tick count to a multiple of the period. After a code or enable change, the first event comes at the next such boundary.
- R7: An event is a single-cycle pulse in the cycle after the tick: `evt_o`=1, `irq_req_o`=1 and `stat_set_o`=0xC0 (bit 7 interrupt flag, bit 6 periodic flag). In every other cycle `stat_set_o` is 0x00.
- R8: No event occurs in a cycle that does not follow a tick. Changing the code or the enable between ticks never creates an extra event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz time-base tick |
| rate_code | input | 4 | Rate-select code, 0 disables |
| pie_en | input | 1 | Periodic interrupt enable |
| evt_o | output | 1 | One-cycle periodic event pulse |
| stat_set_o | output | 8 | Status bits to OR into the status register (0xC0 on an event) |
| irq_req_o | output | 1 | Interrupt request strobe |

## Verification
The bench measures the gap between consecutive events for every unfolded code from 3 to 15. A wrong shift would show up as a gap off by a factor of two. It also runs codes 1 and 2, where a design without the fold would fire every tick or every other tick. The code is switched on partway through a period to check that the first event lands on the shared boundary (27 ticks later, not 32), which a design that reloads a down-counter on a write would miss. Sparse ticks with register changes between them expose any design that fires on a write instead of on a tick.

// File: rtl/prg_pkg.sv
package prg_pkg;

   typedef enum logic [0:0] {
      DET_NEXT_ZERO = 1'b0,
      DET_LOW_ONES  = 1'b1
   } det_style_e;

   function automatic int fold_code(input int code, input int limit, input int add);
      if (code != 0 && code <= limit)
         return code + add;
      return code;
   endfunction

   function automatic int max_eff(input int code_w, input int limit, input int add);
      int top_code;
      top_code = (1 << code_w) - 1;
      return ((limit + add) > top_code) ? (limit + add) : top_code;
   endfunction

endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode #(
   parameter int CODE_W     = 4,
   parameter int CNT_W      = 16,
   parameter int FOLD_LIMIT = 2,
   parameter int FOLD_ADD   = 7
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              en_i,
   output logic              active_o,
   output logic [CNT_W-1:0]  mask_o
);
   localparam int EFF_W = CODE_W + 2;

   logic [EFF_W-1:0] eff;
   logic             code_nz;

   assign code_nz = (code_i != '0);

   generate
      if (FOLD_LIMIT > 0) begin : g_fold
         always_comb begin
            if (code_nz && (int'(code_i) <= FOLD_LIMIT))
               eff = EFF_W'(int'(code_i) + FOLD_ADD);
            else
               eff = EFF_W'(code_i);
         end
      end else begin : g_nofold
         assign eff = EFF_W'(code_i);
      end
   endgenerate

   assign active_o = en_i && code_nz;

   // period is 2^(eff-1): mask covers bits below eff-1
   generate
      for (genvar i = 0; i < CNT_W; i++) begin : g_mask
         assign mask_o[i] = ((i + 1) < int'(eff));
      end
   endgenerate

endmodule

// File: rtl/prg_tick_counter.sv
module prg_tick_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_next_o
);
   logic [CNT_W-1:0] cnt_q;

   assign cnt_next_o = cnt_q + CNT_W'(1);
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_next_o;
   end

endmodule

// File: rtl/prg_boundary_detect.sv
module prg_boundary_detect #(
   parameter int              CNT_W     = 16,
   parameter prg_pkg::det_style_e DET_STYLE = prg_pkg::DET_NEXT_ZERO
) (
   input  logic             tick_i,
   input  logic             active_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cnt_next_i,
   input  logic [CNT_W-1:0] mask_i,
   output logic             hit_o
);
   logic crossing;

   generate
      if (DET_STYLE == prg_pkg::DET_NEXT_ZERO) begin : g_next_zero
         assign crossing = ((cnt_next_i & mask_i) == '0);
      end else begin : g_low_ones
         assign crossing = ((cnt_i & mask_i) == mask_i);
      end
   endgenerate

   assign hit_o = tick_i && active_i && crossing;

endmodule

// File: rtl/prg_event_out.sv
module prg_event_out #(
   parameter int             STAT_W     = 8,
   parameter logic [STAT_W-1:0] STAT_FLAGS = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   output logic              evt_o,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_o  <= 1'b0;
         stat_o <= '0;
         irq_o  <= 1'b0;
      end else begin
         evt_o  <= hit_i;
         stat_o <= hit_i ? STAT_FLAGS : '0;
         irq_o  <= hit_i;
      end
   end

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
   parameter int                  CODE_W     = 4,
   parameter int                  CNT_W      = 16,
   parameter int                  FOLD_LIMIT = 2,
   parameter int                  FOLD_ADD   = 7,
   parameter int                  STAT_W     = 8,
   parameter logic [7:0]          STAT_FLAGS = 8'hC0,
   parameter prg_pkg::det_style_e DET_STYLE  = prg_pkg::DET_NEXT_ZERO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              pie_en,
   output logic              evt_o,
   output logic [STAT_W-1:0] stat_set_o,
   output logic              irq_req_o
);
   localparam int MAX_EFF = prg_pkg::max_eff(CODE_W, FOLD_LIMIT, FOLD_ADD);

   if (CNT_W < 16) begin : g_chk_cnt
      $error("tick counter must be at least 16 bits");
   end
   if (CNT_W < MAX_EFF - 1) begin : g_chk_span
      $error("tick counter narrower than the longest period");
   end
   if (STAT_W < 8) begin : g_chk_stat
      $error("status mask must be at least 8 bits");
   end
   if (FOLD_LIMIT < 0 || FOLD_ADD < 0) begin : g_chk_fold
      $error("fold parameters must be non-negative");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] mask_w;
   logic             active_w;
   logic             hit_w;

   prg_rate_decode #(
      .CODE_W    (CODE_W),
      .CNT_W     (CNT_W),
      .FOLD_LIMIT(FOLD_LIMIT),
      .FOLD_ADD  (FOLD_ADD)
   ) u_dec (
      .code_i  (rate_code),
      .en_i    (pie_en),
      .active_o(active_w),
      .mask_o  (mask_w)
   );

   prg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_en),
      .cnt_o     (cnt_q),
      .cnt_next_o(cnt_next)
   );

   prg_boundary_detect #(.CNT_W(CNT_W), .DET_STYLE(DET_STYLE)) u_det (
      .tick_i    (tick_en),
      .active_i  (active_w),
      .cnt_i     (cnt_q),
      .cnt_next_i(cnt_next),
      .mask_i    (mask_w),
      .hit_o     (hit_w)
   );

   prg_event_out #(
      .STAT_W    (STAT_W),
      .STAT_FLAGS(STAT_W'(STAT_FLAGS))
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (hit_w),
      .evt_o (evt_o),
      .stat_o(stat_set_o),
      .irq_o (irq_req_o)
   );

endmodule

module prg_checker #(
   parameter int CODE_W = 4,
   parameter int CNT_W  = 16,
   parameter int STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic [CODE_W-1:0] rate_code,
   input logic              pie_en,
   input logic              evt_o,
   input logic [STAT_W-1:0] stat_set_o,
   input logic              irq_req_o,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  mask_w
);
   AST_CODE_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> ($past(rate_code) != '0)); // R2
   AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> $past(pie_en)); // R3
   AST_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> ((cnt_q & $past(mask_w)) == '0)); // R6
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o); // R7
   AST_IRQ_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> (irq_req_o && stat_set_o == STAT_W'(8'hC0))); // R7
   AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> $past(tick_en)); // R8
endmodule

bind periodic_irq_gen prg_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .rate_code (rate_code),
   .pie_en    (pie_en),
   .evt_o     (evt_o),
   .stat_set_o(stat_set_o),
   .irq_req_o (irq_req_o),
   .cnt_q     (cnt_q),
   .mask_w    (mask_w)
);

// File: tb/periodic_irq_gen_test.sv
module periodic_irq_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [3:0] rate_code = 4'd0;
   logic       pie_en = 1'b0;
   logic       evt_o;
   logic [7:0] stat_set_o;
   logic       irq_req_o;

   int tests = 0;
   int fails = 0;
   string cur_req = "R1";
   bit done = 0;

   // reference model state
   int  m_cnt = 0;
   bit  m_evt = 0;
   longint tick_total = 0;
   int  evt_seen = 0;
   longint prev_tick = 0;
   longint last_gap = 0;
   bit  have_prev = 0;
   int  last_evt_cnt = 0;

   always #10 clk = ~clk;

   periodic_irq_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code),
      .pie_en(pie_en), .evt_o(evt_o), .stat_set_o(stat_set_o), .irq_req_o(irq_req_o)
   );

   function automatic int period_of(input int code);
      int c;
      c = code;
      if (c == 1 || c == 2) c = c + 7;
      return 1 << (c - 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0;
         m_evt = 0;
      end else begin
         m_evt = 0;
         if (tick_en) begin
            int nxt;
            nxt = (m_cnt + 1) % 65536;
            if (pie_en && rate_code != 0 && (nxt % period_of(rate_code)) == 0)
               m_evt = 1;
            m_cnt = nxt;
            tick_total = tick_total + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #2;
      if (!done) begin
         check(evt_o == m_evt, cur_req, "evt_o", evt_o, m_evt);
         check(irq_req_o == m_evt, cur_req, "irq_req_o", irq_req_o, m_evt);
         check(stat_set_o == (m_evt ? 8'hC0 : 8'h00), cur_req, "stat_set_o",
               stat_set_o, m_evt ? 8'hC0 : 8'h00);
         if (evt_o) begin
            if (have_prev) last_gap = tick_total - prev_tick;
            prev_tick = tick_total;
            have_prev = 1;
            last_evt_cnt = m_cnt;
            evt_seen++;
         end
      end
   end

   task automatic wait_events(input int n);
      int start;
      start = evt_seen;
      while (evt_seen < start + n) @(negedge clk);
   endtask

   task automatic run_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(input int code, input string req);
      cur_req = req;
      @(negedge clk);
      rate_code = code[3:0];
      pie_en = 1'b1;
      have_prev = 0;
      wait_events(2);
      check(last_gap == period_of(code), req, $sformatf("gap code %0d", code),
            last_gap, period_of(code));
      check((last_evt_cnt % period_of(code)) == 0, "R6", "event count alignment",
            last_evt_cnt % period_of(code), 0);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         done = 1;
         fails++;
         tests++;
         $display("FAIL watchdog expired in %s actual=1 expected=0", cur_req);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int base;
      longint t0;
      // R1 reset state
      cur_req = "R1";
      run_cycles(3);
      check(evt_o == 0 && irq_req_o == 0, "R1", "evt/irq in reset", evt_o, 0);
      check(stat_set_o == 8'h00, "R1", "stat in reset", stat_set_o, 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check(evt_o == 0 && stat_set_o == 0, "R1", "first cycle after reset", evt_o, 0);

      tick_en = 1'b1;
      // R3 enable low
      cur_req = "R3";
      rate_code = 4'd3;
      pie_en = 1'b0;
      base = evt_seen;
      run_cycles(200);
      check(evt_seen == base, "R3", "events with enable low", evt_seen - base, 0);

      // R2 code zero
      cur_req = "R2";
      rate_code = 4'd0;
      pie_en = 1'b1;
      base = evt_seen;
      run_cycles(200);
      check(evt_seen == base, "R2", "events with code 0", evt_seen - base, 0);

      // R6 alignment on enable mid-period
      cur_req = "R6";
      pie_en = 1'b0;
      while ((m_cnt % 32) != 5) @(negedge clk);
      rate_code = 4'd6;
      pie_en = 1'b1;
      t0 = tick_total;
      wait_events(1);
      check(prev_tick - t0 == 27, "R6", "ticks to first boundary", prev_tick - t0, 27);
      check((last_evt_cnt % 32) == 0, "R6", "first event count", last_evt_cnt % 32, 0);

      // R4 spacing for unfolded codes
      for (int c = 3; c <= 15; c++) measure(c, "R4");
      // R5 folded codes
      measure(1, "R5");
      measure(2, "R5");

      // R8 sparse ticks with register churn between ticks
      cur_req = "R8";
      rate_code = 4'd3;
      pie_en = 1'b1;
      base = evt_seen;
      for (int i = 0; i < 60; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
         tick_en = 1'b0;
         rate_code = (i % 2 == 0) ? 4'd4 : 4'd3;
         pie_en = (i % 3 != 0);
         @(negedge clk);
         rate_code = 4'd3;
         pie_en = 1'b1;
         @(negedge clk);
      end
      check(evt_seen > base, "R8", "events with sparse ticks", evt_seen - base, 1);
      base = evt_seen;
      tick_en = 1'b0;
      for (int i = 0; i < 50; i++) begin
         rate_code = i[3:0];
         pie_en = i[0];
         @(negedge clk);
      end
      check(evt_seen == base, "R8", "events without ticks", evt_seen - base, 0);

      // R7 pulse content at a live event
      cur_req = "R7";
      rate_code = 4'd3;
      pie_en = 1'b1;
      tick_en = 1'b1;
      while (!evt_o) @(negedge clk);
      check(stat_set_o == 8'hC0, "R7", "status mask on event", stat_set_o, 8'hC0);
      check(irq_req_o == 1'b1, "R7", "irq on event", irq_req_o, 1);
      @(negedge clk);
      check(evt_o == 1'b0 && stat_set_o == 8'h00, "R7", "pulse width", evt_o, 0);

      // R1 reset mid-run clears the count
      cur_req = "R1";
      rst_n = 1'b0;
      @(negedge clk);
      check(evt_o == 0 && stat_set_o == 0, "R1", "outputs in second reset", evt_o, 0);
      rst_n = 1'b1;
      rate_code = 4'd3;
      t0 = tick_total;
      wait_events(1);
      check(prev_tick - t0 == 4, "R1", "count restarts at zero", prev_tick - t0, 4);

      run_cycles(4);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule